// File: doc/BRIEF.md
# Black-Level Clamp Loop Controller

This block closes the digital side of a black-level clamp around an imaging front end. A 10-bit ADC sample stream arrives once per pixel clock. While a window pulse marks the shielded (optically dark) pixels of a line, the block compares each sample with a programmable black target. The target has quarter-LSB resolution. The block sums the differences and keeps a count of the samples it took.

When the line-sync pulse arrives, the window sum is turned into an approximate mean by a power-of-two division. The mean is scaled down by a programmable loop-gain shift and added to a signed correction integrator. The integrator saturates at its limits and drives an external correction DAC. A rate setting can restrict updates to one line in 2, 4 or 8.

With the loop disabled, the output is forced to the target value, so the register then acts as a plain offset adjustment.

Top module: `clamp_loop`

## Requirements
- R1: While reset is asserted, `corr_code` is 0.
- R2: When `loop_en` is 0 at a rising edge, `corr_code` after that edge equals `clamp_level` zero-extended. The same edge clears the window sum, the sample count and the line phase.
- R3: A sample counts toward the window only when `clamp_win` is 1 and `line_sync` is 0 at that edge. Its error is `clamp_level - 4*adc_data`, in quarter-LSB units, so `clamp_level` is a 6.2 fixed-point target.
- R4: At an enabled `line_sync` edge that applies, the integrator takes `corr + ((sum >>> floor(log2(count))) >>> loop_shift)` with arithmetic shifts. The new value is visible after that edge. The sum and the count are then cleared.
- R5: While the loop is enabled, `corr_code` does not change on any edge where `line_sync` is 0.
- R6: A 3-bit line phase starts at 0 and advances by one on each enabled `line_sync`. A line applies only when the phase modulo 2^`rate_sel` is 0, so `rate_sel` 0, 1, 2 and 3 select every line, every 2nd, every 4th and every 8th.
- R7: A line whose window holds zero samples leaves `corr_code` unchanged. Its `line_sync` still advances the phase.
- R8: The integrator saturates at -2048 and +2047 instead of wrapping.
- R9: A window of a single sample updates the loop with that sample's error as the mean.
- R10: At most 255 samples per line are taken. Further window samples in the same line are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adc_data | input | 10 | ADC sample, unsigned |
| clamp_win | input | 1 | High over the shielded black pixels |
| line_sync | input | 1 | One-cycle line start pulse; closes the previous window |
| clamp_level | input | 8 | Black target, quarter-LSB units (0 to 63.75) |
| loop_en | input | 1 | 1 runs the loop, 0 forces the fixed offset |
| rate_sel | input | 2 | Update every 2^rate_sel lines |
| loop_shift | input | 3 | Loop-gain right shift applied to the mean |
| corr_code | output | 12 | Signed correction code for the DAC |

## Verification
Every result of this block is due exactly one rising edge after the stimulus that causes it. A disabled cycle or a closing `line_sync` sets `corr_code` at that edge, and any other enabled cycle must leave it untouched at that edge. The bench therefore drives each input set at a falling edge and lets one rising edge pass. It then compares `corr_code` at the next falling edge with a model that applies the same input set to its own sum, count, phase and integrator. The per-cycle check is tagged with the requirement that governs that cycle: skipped line, empty window, single sample, capped count, saturation or ordinary update.

// File: rtl/clamp_pkg.sv
package clamp_pkg;
   typedef enum logic [1:0] {
      RATE_EVERY1 = 2'd0,
      RATE_EVERY2 = 2'd1,
      RATE_EVERY4 = 2'd2,
      RATE_EVERY8 = 2'd3
   } rate_e;

   function automatic int err_width(input int adc_w, input int frac_w);
      return adc_w + frac_w + 1;
   endfunction
endpackage

// File: rtl/clamp_err_accum.sv
module clamp_err_accum #(
   parameter int ADC_W  = 10,
   parameter int FRAC_W = 2,
   parameter int REF_W  = 8,
   parameter int CNT_W  = 8,
   localparam int ERR_W = clamp_pkg::err_width(ADC_W, FRAC_W),
   localparam int ACC_W = ERR_W + CNT_W
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    loop_en,
   input  logic                    clamp_win,
   input  logic                    line_sync,
   input  logic [ADC_W-1:0]        adc_data,
   input  logic [REF_W-1:0]        clamp_level,
   output logic signed [ACC_W-1:0] win_sum,
   output logic [CNT_W-1:0]        win_cnt
);
   logic signed [ERR_W-1:0] ref_q;
   logic signed [ERR_W-1:0] smp_q;
   logic signed [ERR_W-1:0] err;
   logic                    cnt_full;

   assign ref_q    = ERR_W'(clamp_level);
   assign smp_q    = ERR_W'({adc_data, {FRAC_W{1'b0}}});
   assign err      = ref_q - smp_q;
   assign cnt_full = &win_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_sum <= '0;
         win_cnt <= '0;
      end else if (!loop_en || line_sync) begin
         win_sum <= '0;
         win_cnt <= '0;
      end else if (clamp_win && !cnt_full) begin
         win_sum <= win_sum + ACC_W'(err);
         win_cnt <= win_cnt + CNT_W'(1);
      end
   end
endmodule

// File: rtl/clamp_line_pacer.sv
module clamp_line_pacer #(
   parameter int RATE_W = 2,
   localparam int PH_W  = (1 << RATE_W) - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              loop_en,
   input  logic              line_sync,
   input  logic [RATE_W-1:0] rate_sel,
   output logic              apply_line
);
   logic [PH_W-1:0] phase;
   logic [PH_W-1:0] mask;

   assign mask       = (PH_W'(1) << rate_sel) - PH_W'(1);
   assign apply_line = ((phase & mask) == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         phase <= '0;
      else if (!loop_en)
         phase <= '0;
      else if (line_sync)
         phase <= phase + PH_W'(1);
   end
endmodule

// File: rtl/clamp_step_calc.sv
module clamp_step_calc #(
   parameter int ACC_W        = 21,
   parameter int CNT_W        = 8,
   parameter int SHIFT_W      = 3,
   parameter bit AVG_BY_COUNT = 1'b1,
   localparam int IDX_W       = (CNT_W > 1) ? $clog2(CNT_W) : 1
) (
   input  logic signed [ACC_W-1:0] win_sum,
   input  logic [CNT_W-1:0]        win_cnt,
   input  logic [SHIFT_W-1:0]      loop_shift,
   output logic signed [ACC_W-1:0] step
);
   logic signed [ACC_W-1:0] mean;

   generate
      if (AVG_BY_COUNT) begin : g_mean
         logic [IDX_W-1:0] top_bit;
         always_comb begin
            top_bit = '0;
            for (int i = 0; i < CNT_W; i++)
               if (win_cnt[i]) top_bit = IDX_W'(i);
         end
         assign mean = win_sum >>> top_bit;
      end else begin : g_sum
         assign mean = win_sum;
      end
   endgenerate

   assign step = mean >>> loop_shift;
endmodule

// File: rtl/clamp_integrator.sv
module clamp_integrator #(
   parameter int CORR_W = 12,
   parameter int ACC_W  = 21,
   parameter int REF_W  = 8,
   localparam int SUM_W = ((CORR_W > ACC_W) ? CORR_W : ACC_W) + 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     loop_en,
   input  logic                     line_sync,
   input  logic                     apply_line,
   input  logic                     have_samples,
   input  logic signed [ACC_W-1:0]  step,
   input  logic [REF_W-1:0]         clamp_level,
   output logic signed [CORR_W-1:0] corr
);
   localparam logic signed [SUM_W-1:0] C_MAX = SUM_W'((64'sd1 <<< (CORR_W - 1)) - 64'sd1);
   localparam logic signed [SUM_W-1:0] C_MIN = -C_MAX - SUM_W'(1);

   logic signed [SUM_W-1:0]  sum;
   logic signed [CORR_W-1:0] sat;
   logic                     do_update;

   assign sum       = SUM_W'(corr) + SUM_W'(step);
   assign do_update = line_sync && apply_line && have_samples;

   always_comb begin
      if (sum > C_MAX)
         sat = C_MAX[CORR_W-1:0];
      else if (sum < C_MIN)
         sat = C_MIN[CORR_W-1:0];
      else
         sat = sum[CORR_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         corr <= '0;
      else if (!loop_en)
         corr <= CORR_W'(clamp_level);
      else if (do_update)
         corr <= sat;
   end
endmodule

// File: rtl/clamp_loop.sv
module clamp_loop #(
   parameter int ADC_W        = 10,
   parameter int FRAC_W       = 2,
   parameter int REF_W        = 8,
   parameter int CNT_W        = 8,
   parameter int CORR_W       = 12,
   parameter int RATE_W       = 2,
   parameter int SHIFT_W      = 3,
   parameter bit AVG_BY_COUNT = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [ADC_W-1:0]         adc_data,
   input  logic                     clamp_win,
   input  logic                     line_sync,
   input  logic [REF_W-1:0]         clamp_level,
   input  logic                     loop_en,
   input  logic [RATE_W-1:0]        rate_sel,
   input  logic [SHIFT_W-1:0]       loop_shift,
   output logic signed [CORR_W-1:0] corr_code
);
   localparam int ERR_W = clamp_pkg::err_width(ADC_W, FRAC_W);
   localparam int ACC_W = ERR_W + CNT_W;

   generate
      if (REF_W > ADC_W + FRAC_W) begin : g_bad_ref
         $error("clamp_loop: target wider than the fixed-point sample");
      end
      if (CORR_W <= REF_W) begin : g_bad_corr
         $error("clamp_loop: correction too narrow to hold the fixed offset");
      end
      if (RATE_W < 1 || RATE_W > 3) begin : g_bad_rate
         $error("clamp_loop: RATE_W out of range");
      end
      if (CORR_W > 62) begin : g_bad_wide
         $error("clamp_loop: CORR_W too large");
      end
   endgenerate

   logic signed [ACC_W-1:0] win_sum;
   logic [CNT_W-1:0]        win_cnt;
   logic                    apply_line;
   logic signed [ACC_W-1:0] step;

   clamp_err_accum #(
      .ADC_W (ADC_W), .FRAC_W(FRAC_W), .REF_W(REF_W), .CNT_W(CNT_W)
   ) u_accum (
      .clk        (clk),
      .rst_n      (rst_n),
      .loop_en    (loop_en),
      .clamp_win  (clamp_win),
      .line_sync  (line_sync),
      .adc_data   (adc_data),
      .clamp_level(clamp_level),
      .win_sum    (win_sum),
      .win_cnt    (win_cnt)
   );

   clamp_line_pacer #(.RATE_W(RATE_W)) u_pacer (
      .clk       (clk),
      .rst_n     (rst_n),
      .loop_en   (loop_en),
      .line_sync (line_sync),
      .rate_sel  (rate_sel),
      .apply_line(apply_line)
   );

   clamp_step_calc #(
      .ACC_W(ACC_W), .CNT_W(CNT_W), .SHIFT_W(SHIFT_W), .AVG_BY_COUNT(AVG_BY_COUNT)
   ) u_step (
      .win_sum   (win_sum),
      .win_cnt   (win_cnt),
      .loop_shift(loop_shift),
      .step      (step)
   );

   clamp_integrator #(
      .CORR_W(CORR_W), .ACC_W(ACC_W), .REF_W(REF_W)
   ) u_integ (
      .clk         (clk),
      .rst_n       (rst_n),
      .loop_en     (loop_en),
      .line_sync   (line_sync),
      .apply_line  (apply_line),
      .have_samples(|win_cnt),
      .step        (step),
      .clamp_level (clamp_level),
      .corr        (corr_code)
   );
endmodule

// File: rtl/clamp_loop_chk.sv
module clamp_loop_chk #(
   parameter int REF_W  = 8,
   parameter int CNT_W  = 8,
   parameter int CORR_W = 12,
   parameter int ACC_W  = 21
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     loop_en,
   input logic                     line_sync,
   input logic [REF_W-1:0]         clamp_level,
   input logic signed [CORR_W-1:0] corr_code,
   input logic                     apply_line,
   input logic [CNT_W-1:0]         win_cnt,
   input logic signed [ACC_W-1:0]  step
);
   AST_DISABLED_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
      !loop_en |=> corr_code == CORR_W'($past(clamp_level))); // R2

   AST_HOLD_MID_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      (loop_en && !line_sync) |=> $stable(corr_code)); // R5

   AST_SKIPPED_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      (loop_en && line_sync && !apply_line) |=> $stable(corr_code)); // R6

   AST_EMPTY_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      (loop_en && line_sync && win_cnt == '0) |=> $stable(corr_code)); // R7

   AST_NO_WRAP_UP: assert property (@(posedge clk) disable iff (!rst_n)
      (loop_en && line_sync && !step[ACC_W-1]) |=> corr_code >= $past(corr_code)); // R8

   AST_NO_WRAP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (loop_en && line_sync && step[ACC_W-1]) |=> corr_code <= $past(corr_code)); // R8
endmodule

bind clamp_loop clamp_loop_chk #(
   .REF_W(REF_W), .CNT_W(CNT_W), .CORR_W(CORR_W), .ACC_W(ACC_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .loop_en    (loop_en),
   .line_sync  (line_sync),
   .clamp_level(clamp_level),
   .corr_code  (corr_code),
   .apply_line (apply_line),
   .win_cnt    (win_cnt),
   .step       (step)
);

// File: tb/clamp_loop_bench.sv
module clamp_loop_bench;
   localparam int CMAX = 2047;
   localparam int CMIN = -2048;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [9:0]        adc_data = '0;
   logic              clamp_win = 1'b0;
   logic              line_sync = 1'b0;
   logic [7:0]        clamp_level = '0;
   logic              loop_en = 1'b0;
   logic [1:0]        rate_sel = '0;
   logic [2:0]        loop_shift = '0;
   logic signed [11:0] corr_code;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   int m_sum = 0, m_cnt = 0, m_phase = 0, m_corr = 0;

   always #10 clk = ~clk;

   clamp_loop u_clamp_loop (
      .clk(clk), .rst_n(rst_n), .adc_data(adc_data), .clamp_win(clamp_win),
      .line_sync(line_sync), .clamp_level(clamp_level), .loop_en(loop_en),
      .rate_sel(rate_sel), .loop_shift(loop_shift), .corr_code(corr_code)
   );

   function automatic int top_bit(input int c);
      int r = 0;
      for (int i = 0; i < 8; i++) if (c[i]) r = i;
      return r;
   endfunction

   function automatic int clip(input int v, input int lo, input int hi);
      return (v < lo) ? lo : (v > hi) ? hi : v;
   endfunction

   task automatic check(input string tag, input int exp);
      checks++;
      if (int'(corr_code) != exp) begin
         fails++;
         $display("FAIL %s: corr_code actual %0d expected %0d", tag, corr_code, exp);
      end
   endtask

   // one pixel: drive at falling edge, model at rising edge, compare at next falling edge
   task automatic pix(input bit en, input bit win, input bit sync, input int data);
      string tag;
      int sum;
      loop_en = en; clamp_win = win; line_sync = sync; adc_data = 10'(data);
      @(posedge clk);
      tag = "R5";
      if (!en) begin
         tag = "R2";
         m_corr = clamp_level; m_sum = 0; m_cnt = 0; m_phase = 0;
      end else if (sync) begin
         if (m_cnt == 0) tag = "R7";
         else if ((m_phase & ((1 << rate_sel) - 1)) != 0) tag = "R6";
         else begin
            sum = m_corr + ((m_sum >>> top_bit(m_cnt)) >>> loop_shift);
            if (m_cnt == 255) tag = "R10";
            else if (m_cnt == 1) tag = "R9";
            else if (sum > CMAX || sum < CMIN) tag = "R8";
            else tag = "R3/R4";
            m_corr = clip(sum, CMIN, CMAX);
         end
         m_sum = 0; m_cnt = 0; m_phase = (m_phase + 1) % 8;
      end else if (win && m_cnt < 255) begin
         m_sum += int'(clamp_level) - 4 * data;
         m_cnt++;
      end
      @(negedge clk);
      check(tag, m_corr);
   endtask

   task automatic line(input int ws, input int wl, input int len, input int mean, input int noise);
      for (int i = 0; i < len; i++) begin
         int d = clip(mean + $urandom_range(2 * noise) - noise, 0, 1023);
         pix(1'b1, (i >= ws) && (i < ws + wl), i == 0, d);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      clamp_level = 8'd200;
      repeat (3) @(negedge clk);
      check("R1", 0);                           // R1 reset value
      rst_n = 1'b1;
      for (int i = 0; i < 4; i++) pix(1'b0, 1'b1, 1'b0, 5); // R2 fixed offset
      clamp_level = 8'd37;
      pix(1'b0, 1'b0, 1'b0, 0);                 // R2 follows register

      // R8 saturate upward: dark samples below target
      clamp_level = 8'd255; rate_sel = 2'd0; loop_shift = 3'd0;
      for (int l = 0; l < 12; l++) line(2, 24, 40, 0, 0);
      // R8 saturate downward: bright samples
      for (int l = 0; l < 4; l++) line(2, 24, 40, 1023, 0);
      // R7 empty windows
      for (int l = 0; l < 3; l++) line(0, 0, 20, 500, 0);
      // R9 single sample windows
      clamp_level = 8'd128; loop_shift = 3'd1;
      for (int l = 0; l < 3; l++) line(5, 1, 12, 40, 8);
      // R10 overlong window
      loop_shift = 3'd4;
      line(2, 300, 320, 20, 4);
      line(2, 300, 320, 40, 4);
      // R6 every rate
      for (int r = 0; r < 4; r++) begin
         rate_sel = 2'(r);
         for (int l = 0; l < 10; l++) line(3, 20 + $urandom_range(10), 40, 30, 6);
      end
      // disable mid-run then restart: phase reset
      pix(1'b0, 1'b0, 1'b0, 0);
      rate_sel = 2'd1;
      for (int l = 0; l < 4; l++) line(1, 25, 35, 35, 5);
      // random lines
      for (int l = 0; l < 150; l++) begin
         clamp_level = 8'($urandom_range(255));
         rate_sel    = 2'($urandom_range(3));
         loop_shift  = 3'($urandom_range(7));
         if ($urandom_range(19) == 0) pix(1'b0, 1'b0, 1'b0, 0);
         line($urandom_range(4), $urandom_range(40), 20 + $urandom_range(40),
              $urandom_range(1023), $urandom_range(30));
      end
      pix(1'b1, 1'b0, 1'b1, 0);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule